// File: doc/BRIEF.md
# Register-Staged Two-Channel Transaction Bridge

This block sits on an APB bus as a slave and turns software register writes into single transactions on one of two downstream channels. For a channel, software stages an enable, a direction, a width code, a target address and outgoing data. It then writes a separate launch register. The bridge checks that the staged setup is legal and issues one read or write of 1, 2 or 4 bytes through a request/acknowledge master port. It then records the outcome.

On a good completion the channel's sticky done flag in the status register is set. A read also stores the returned data, narrowed to the access width, in that channel's result register. A failed downstream access changes neither the flag nor the stored data. The APB side always answers at once and never waits for the downstream side. Software polls a busy flag, or the done flags, to find out when a transaction has finished.

Top module: `apb_dual_bridge`

## Requirements
- R1: After reset the identification word at byte offset 0x00 reads 0x000000A1, and the busy flag, the status register and every staged and result register read zero.
- R2: Each channel has five staged words that read back exactly what was written: enable, direction, width, target address and outgoing data. Channel 0 holds them at 0x10, 0x14, 0x18, 0x1C and 0x20. Channel 1 holds them at 0x28, 0x2C, 0x30, 0x34 and 0x38.
- R3: A write to the launch register at 0x04 issues exactly one downstream transaction only when exactly one of the two enable words has bit 0 set. The transaction goes to that channel and carries its staged address (dn_chan 0 or 1). With no channel enabled, or with both enabled, nothing is issued and no done flag changes.
- R4: Bit 0 of the direction word selects a read when 1 and a write when 0 (dn_we high means write).
- R5: The width word's bits 1:0 give the byte count minus one, and the code appears on dn_size. Code 0 is 1 byte, code 1 is 2 bytes and code 3 is 4 bytes.
- R6: A launch is rejected, with no transaction and no done flag, when the width word has any bit above bit 1 set or holds code 2.
- R7: A completion acknowledged without error sets status bit 16 for channel 0 or bit 17 for channel 1 (status at 0x48). These bits stay set until software writes 1 to them, and every other status bit reads zero.
- R8: A successful read stores the returned data in the channel's result register: 0x84 for channel 0, 0x90 for channel 1. Only bits 7:0 are kept for 1-byte reads and bits 15:0 for 2-byte reads, with the upper bits zero. Writes leave both result registers unchanged, and the result registers cannot be written from APB.
- R9: A completion flagged with dn_err updates neither the result register nor the done flag.
- R10: Every APB access completes with pready high and pslverr low. Unmapped or misaligned addresses read as zero, writes to them are dropped, and the identification word cannot be written.
- R11: Outgoing data on dn_wdata is the staged word with the bytes outside the access width forced to zero.
- R12: Bit 0 of the launch register reads 1 while a transaction is outstanding. A launch written while one is outstanding is ignored, and the request and its fields stay constant until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| dn_req | output | 1 | Downstream request, held until acknowledged |
| dn_chan | output | 1 | Downstream channel number |
| dn_we | output | 1 | Downstream write when high |
| dn_size | output | 2 | Byte count minus one |
| dn_addr | output | 32 | Downstream target address |
| dn_wdata | output | 32 | Downstream write data, width-masked |
| dn_ack | input | 1 | Downstream acknowledge, one cycle |
| dn_err | input | 1 | Downstream error, valid with dn_ack |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
The bench builds the bridge with its default parameters: a 12-bit APB address, 32-bit data, 32-bit downstream addresses and identification value 0xA1. Only these values place the register map at its fixed offsets. With them, every channel, direction and width code can be reached, including the rejected code 2 and width words with high bits set. The downstream responder varies its acknowledge delay from zero to several cycles, so back-to-back launches land both while busy and after completion.

// File: rtl/apbb_pkg.sv
package apbb_pkg;

  localparam int unsigned DW = 32;

  // register byte offsets that software depends on
  localparam int unsigned OFS_IDENT  = 'h00;
  localparam int unsigned OFS_LAUNCH = 'h04;
  localparam int unsigned OFS_STAT   = 'h48;
  localparam int unsigned STAT_BIT0  = 16;

  // per-channel staged block: enable, direction, width, address, data
  function automatic int unsigned stage_base(input int unsigned ch);
    return 'h10 + ch * 'h18;
  endfunction

  function automatic int unsigned result_ofs(input int unsigned ch);
    return 'h84 + ch * 'h0C;
  endfunction

  // keep only the byte lanes covered by a width code
  function automatic logic [DW-1:0] lane_keep(input logic [1:0] code);
    logic [DW-1:0] m;
    case (code)
      2'd0:    m = DW'(32'h0000_00FF);
      2'd1:    m = DW'(32'h0000_FFFF);
      default: m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/apbb_rst_sync.sv
module apbb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/apbb_launch.sv
module apbb_launch
  import apbb_pkg::*;
#(
  parameter int unsigned DNAW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic [1:0]      sel_en_i,
  input  logic [1:0]      mode_rd_i,
  input  logic [DW-1:0]   size_i  [2],
  input  logic [DNAW-1:0] addr_i  [2],
  input  logic [DW-1:0]   wdata_i [2],
  output logic            busy_o,
  output logic            dn_req_o,
  output logic            dn_chan_o,
  output logic            dn_we_o,
  output logic [1:0]      dn_size_o,
  output logic [DNAW-1:0] dn_addr_o,
  output logic [DW-1:0]   dn_wdata_o,
  input  logic            dn_ack_i,
  input  logic            dn_err_i,
  input  logic [DW-1:0]   dn_rdata_i,
  output logic            cpl_ok_o,
  output logic            cpl_rd_o,
  output logic            cpl_chan_o,
  output logic [DW-1:0]   cpl_rdata_o
);

  logic            busy_q, busy_d;
  logic            ch_q, ch_d;
  logic            we_q, we_d;
  logic [1:0]      sz_q, sz_d;
  logic [DNAW-1:0] addr_q, addr_d;
  logic [DW-1:0]   wd_q, wd_d;

  logic            pick;
  logic            one_hot;
  logic [DW-1:0]   sz_word;
  logic            size_ok;
  logic            launch;

  always_comb begin
    pick    = sel_en_i[1];
    one_hot = sel_en_i[0] ^ sel_en_i[1];
    sz_word = size_i[pick];
    size_ok = (sz_word[DW-1:2] == '0) && (sz_word[1:0] != 2'd2);
    launch  = trig_i && !busy_q && one_hot && size_ok;
  end

  always_comb begin
    busy_d = busy_q;
    ch_d   = ch_q;
    we_d   = we_q;
    sz_d   = sz_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    if (launch) begin
      busy_d = 1'b1;
      ch_d   = pick;
      we_d   = ~mode_rd_i[pick];
      sz_d   = sz_word[1:0];
      addr_d = addr_i[pick];
      wd_d   = wdata_i[pick] & lane_keep(sz_word[1:0]);
    end else if (busy_q && dn_ack_i) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ch_q   <= 1'b0;
      we_q   <= 1'b0;
      sz_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      if (launch) begin
        ch_q   <= ch_d;
        we_q   <= we_d;
        sz_q   <= sz_d;
        addr_q <= addr_d;
        wd_q   <= wd_d;
      end
    end
  end

  assign busy_o      = busy_q;
  assign dn_req_o    = busy_q;
  assign dn_chan_o   = ch_q;
  assign dn_we_o     = we_q;
  assign dn_size_o   = sz_q;
  assign dn_addr_o   = addr_q;
  assign dn_wdata_o  = wd_q;
  assign cpl_ok_o    = busy_q && dn_ack_i && !dn_err_i;
  assign cpl_rd_o    = busy_q && dn_ack_i && !dn_err_i && !we_q;
  assign cpl_chan_o  = ch_q;
  assign cpl_rdata_o = dn_rdata_i & lane_keep(sz_q);

  // R12: request and its fields hold until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_o && !dn_ack_i |=> dn_req_o && $stable(dn_addr_o) && $stable(dn_chan_o)
                             && $stable(dn_we_o) && $stable(dn_size_o));

  // R12: an acknowledge ends the request
  p_ack_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_o && dn_ack_i |=> !dn_req_o);

  // R3: a request only starts after a launch write
  p_launch_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req_o) |-> $past(trig_i));

  // R6: the unsupported width code never reaches the port
  p_size_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_o |-> dn_size_o != 2'd2);

  // R11: unused byte lanes are zero on narrow writes
  p_wdata_lanes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_o && dn_size_o == 2'd0 |-> dn_wdata_o[DW-1:8] == '0);

endmodule

// File: rtl/apbb_regs.sv
module apbb_regs
  import apbb_pkg::*;
#(
  parameter int unsigned AW      = 12,
  parameter int unsigned DNAW    = 32,
  parameter logic [31:0] IDENT   = 32'h0000_00A1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [DW-1:0]   pwdata,
  output logic [DW-1:0]   prdata,
  output logic            trig_o,
  input  logic            busy_i,
  output logic [1:0]      sel_en_o,
  output logic [1:0]      mode_rd_o,
  output logic [DW-1:0]   size_o  [2],
  output logic [DNAW-1:0] addr_o  [2],
  output logic [DW-1:0]   wdata_o [2],
  input  logic            cpl_ok_i,
  input  logic            cpl_rd_i,
  input  logic            cpl_chan_i,
  input  logic [DW-1:0]   cpl_rdata_i
);
  localparam int unsigned WAW = AW - 2;

  logic [WAW-1:0] wa;
  logic           aligned;
  logic           acc;
  logic           wr;

  always_comb begin
    wa      = paddr[AW-1:2];
    aligned = (paddr[1:0] == 2'b00);
    acc     = psel && penable && aligned;
    wr      = acc && pwrite;
  end

  function automatic logic hit(input logic [WAW-1:0] w, input int unsigned ofs);
    return w == WAW'(ofs >> 2);
  endfunction

  assign trig_o = wr && hit(wa, OFS_LAUNCH);

  logic [DW-1:0]   sel_q  [2];
  logic [DW-1:0]   mode_q [2];
  logic [DW-1:0]   size_q [2];
  logic [DNAW-1:0] addr_q [2];
  logic [DW-1:0]   wd_q   [2];
  logic [DW-1:0]   rd_q   [2];
  logic [1:0]      done_q;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam int unsigned BASE = stage_base(c);
    localparam int unsigned RES  = result_ofs(c);

    logic [DW-1:0]   sel_d, mode_d, size_d, wd_d, rd_d;
    logic [DNAW-1:0] addr_d;
    logic            done_d;
    logic            clr;

    always_comb begin
      sel_d  = sel_q[c];
      mode_d = mode_q[c];
      size_d = size_q[c];
      addr_d = addr_q[c];
      wd_d   = wd_q[c];
      if (wr && hit(wa, BASE + 'h00)) sel_d  = pwdata;
      if (wr && hit(wa, BASE + 'h04)) mode_d = pwdata;
      if (wr && hit(wa, BASE + 'h08)) size_d = pwdata;
      if (wr && hit(wa, BASE + 'h0C)) addr_d = DNAW'(pwdata);
      if (wr && hit(wa, BASE + 'h10)) wd_d   = pwdata;
      rd_d   = (cpl_rd_i && cpl_chan_i == 1'(c)) ? cpl_rdata_i : rd_q[c];
      clr    = wr && hit(wa, OFS_STAT) && pwdata[STAT_BIT0 + c];
      done_d = (cpl_ok_i && cpl_chan_i == 1'(c)) || (done_q[c] && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[c]  <= '0;
        mode_q[c] <= '0;
        size_q[c] <= '0;
        addr_q[c] <= '0;
        wd_q[c]   <= '0;
        rd_q[c]   <= '0;
        done_q[c] <= 1'b0;
      end else begin
        sel_q[c]  <= sel_d;
        mode_q[c] <= mode_d;
        size_q[c] <= size_d;
        addr_q[c] <= addr_d;
        wd_q[c]   <= wd_d;
        rd_q[c]   <= rd_d;
        done_q[c] <= done_d;
      end
    end

    assign sel_en_o[c]  = sel_q[c][0];
    assign mode_rd_o[c] = mode_q[c][0];
    assign size_o[c]    = size_q[c];
    assign addr_o[c]    = addr_q[c];
    assign wdata_o[c]   = wd_q[c];

    // R8: result register only moves on a good read completion of its channel
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpl_rd_i && cpl_chan_i == 1'(c)) |=> $stable(rd_q[c]));

    // R7: done flag stays set unless software writes 1 to it
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q[c] && !(wr && hit(wa, OFS_STAT) && pwdata[STAT_BIT0 + c]) |=> done_q[c]);

    // R9: an errored or absent completion never raises the flag
    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[c]) |-> $past(cpl_ok_i) && $past(cpl_chan_i) == 1'(c));
  end

  always_comb begin
    prdata = '0;
    if (acc) begin
      if (hit(wa, OFS_IDENT))  prdata = IDENT;
      if (hit(wa, OFS_LAUNCH)) prdata = DW'(busy_i);
      if (hit(wa, OFS_STAT))   prdata = DW'(done_q) << STAT_BIT0;
      for (int c = 0; c < 2; c++) begin
        if (hit(wa, stage_base(c) + 'h00)) prdata = sel_q[c];
        if (hit(wa, stage_base(c) + 'h04)) prdata = mode_q[c];
        if (hit(wa, stage_base(c) + 'h08)) prdata = size_q[c];
        if (hit(wa, stage_base(c) + 'h0C)) prdata = DW'(addr_q[c]);
        if (hit(wa, stage_base(c) + 'h10)) prdata = wd_q[c];
        if (hit(wa, result_ofs(c)))        prdata = rd_q[c];
      end
    end
  end

endmodule

// File: rtl/apb_dual_bridge.sv
module apb_dual_bridge
  import apbb_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned DNAW  = 32,
  parameter logic [31:0] IDENT = 32'h0000_00A1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [DW-1:0]   pwdata,
  output logic [DW-1:0]   prdata,
  output logic            pready,
  output logic            pslverr,
  output logic            dn_req,
  output logic            dn_chan,
  output logic            dn_we,
  output logic [1:0]      dn_size,
  output logic [DNAW-1:0] dn_addr,
  output logic [DW-1:0]   dn_wdata,
  input  logic            dn_ack,
  input  logic            dn_err,
  input  logic [DW-1:0]   dn_rdata
);
  logic            rst_ns;
  logic            trig;
  logic            busy;
  logic [1:0]      sel_en, mode_rd;
  logic [DW-1:0]   size_w  [2];
  logic [DNAW-1:0] addr_w  [2];
  logic [DW-1:0]   wdata_w [2];
  logic            cpl_ok, cpl_rd, cpl_chan;
  logic [DW-1:0]   cpl_rdata;

  apbb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  apbb_regs #(.AW(AW), .DNAW(DNAW), .IDENT(IDENT)) u_regs (
    .clk(clk), .rst_n(rst_ns),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata),
    .trig_o(trig), .busy_i(busy),
    .sel_en_o(sel_en), .mode_rd_o(mode_rd),
    .size_o(size_w), .addr_o(addr_w), .wdata_o(wdata_w),
    .cpl_ok_i(cpl_ok), .cpl_rd_i(cpl_rd), .cpl_chan_i(cpl_chan),
    .cpl_rdata_i(cpl_rdata)
  );

  apbb_launch #(.DNAW(DNAW)) u_launch (
    .clk(clk), .rst_n(rst_ns), .trig_i(trig),
    .sel_en_i(sel_en), .mode_rd_i(mode_rd),
    .size_i(size_w), .addr_i(addr_w), .wdata_i(wdata_w),
    .busy_o(busy),
    .dn_req_o(dn_req), .dn_chan_o(dn_chan), .dn_we_o(dn_we),
    .dn_size_o(dn_size), .dn_addr_o(dn_addr), .dn_wdata_o(dn_wdata),
    .dn_ack_i(dn_ack), .dn_err_i(dn_err), .dn_rdata_i(dn_rdata),
    .cpl_ok_o(cpl_ok), .cpl_rd_o(cpl_rd), .cpl_chan_o(cpl_chan),
    .cpl_rdata_o(cpl_rdata)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: tb/apb_dual_bridge_tb.sv
module apb_dual_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        dn_req, dn_chan, dn_we;
  logic [1:0]  dn_size;
  logic [31:0] dn_addr, dn_wdata;
  logic        dn_ack = 0, dn_err = 0;
  logic [31:0] dn_rdata = '0;

  always #2.5 clk = ~clk;

  apb_dual_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .dn_req(dn_req), .dn_chan(dn_chan), .dn_we(dn_we),
    .dn_size(dn_size), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // downstream responder
  int          lat_cfg = 0, cnt = 0, n_txn = 0;
  bit          resp_err = 0;
  logic [31:0] resp_rdata = '0;
  logic        got_chan, got_we;
  logic [1:0]  got_size;
  logic [31:0] got_addr, got_wdata;

  always @(negedge clk) begin
    if (dn_ack) begin
      dn_ack = 0; dn_err = 0;
    end else if (dn_req) begin
      if (cnt == 0) begin
        dn_ack = 1; dn_err = resp_err; dn_rdata = resp_rdata;
        got_chan = dn_chan; got_we = dn_we; got_size = dn_size;
        got_addr = dn_addr; got_wdata = dn_wdata;
        n_txn++;
      end else cnt--;
    end else cnt = lat_cfg;
  end

  function automatic logic [31:0] keep(input logic [1:0] c);
    return c == 0 ? 32'hFF : c == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic bit legal(input logic [31:0] s0, s1, sz);
    return (s0[0] ^ s1[0]) && sz[31:2] == 0 && sz[1:0] != 2'd2;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic apb(input bit w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1;
    r = prdata;
    chk("R10 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    @(posedge clk);
    #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r;
    apb(1, a, d, r);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] r);
    apb(0, a, 32'h0, r);
  endtask

  logic [31:0] exp_rd [2];
  logic [1:0]  exp_done;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_0123));
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(12'h000, r); chk("R1 ident", r, 32'hA1);
    rd(12'h004, r); chk("R1 busy", r, 0);
    rd(12'h048, r); chk("R1 status", r, 0);
    rd(12'h084, r); chk("R1 result0", r, 0);
    rd(12'h090, r); chk("R1 result1", r, 0);
    rd(12'h028, r); chk("R1 enable1", r, 0);
    exp_rd[0] = 0; exp_rd[1] = 0; exp_done = 0;

    // R10 unmapped, misaligned, read-only
    rd(12'h094, r); chk("R10 beyond map", r, 0);
    rd(12'hFFC, r); chk("R10 top", r, 0);
    wr(12'h000, 32'h1234_5678); rd(12'h000, r); chk("R10 ident ro", r, 32'hA1);
    wr(12'h01C, 32'hCAFE_0000); wr(12'h01E, 32'h0000_BEEF);
    rd(12'h01C, r); chk("R10 misaligned write", r, 32'hCAFE_0000);
    rd(12'h01E, r); chk("R10 misaligned read", r, 0);
    wr(12'h084, 32'hDEAD_BEEF); rd(12'h084, r); chk("R8 result ro", r, 0);
    wr(12'h020, 32'h0BAD_F00D); rd(12'h020, r); chk("R2 readback", r, 32'h0BAD_F00D);

    // R12 busy and launch while busy
    begin
      int n0;
      wr(12'h010, 1); wr(12'h028, 0); wr(12'h014, 1); wr(12'h018, 3);
      wr(12'h01C, 32'h8000_0010);
      lat_cfg = 6; resp_err = 0; resp_rdata = 32'h1357_9BDF;
      n0 = n_txn;
      wr(12'h004, 0);
      rd(12'h004, r); chk("R12 busy set", r, 1);
      wr(12'h004, 0);
      repeat (12) @(posedge clk);
      chk("R12 launch while busy ignored", n_txn - n0, 1);
      rd(12'h004, r); chk("R12 busy clear", r, 0);
      rd(12'h084, r); chk("R8 word read", r, 32'h1357_9BDF);
      exp_rd[0] = 32'h1357_9BDF; exp_done[0] = 1;
      rd(12'h048, r); chk("R7 done0", r, 32'h0001_0000);
    end

    // random mix
    for (int it = 0; it < 300; it++) begin
      int k, c, n0;
      logic [31:0] s0, s1, md, sz, ad, wd;
      bit go;
      k = $urandom % 8;
      c = (k < 3) ? 0 : (k < 6) ? 1 : ($urandom % 2);
      s0 = {$urandom, 1'b0} | ((k < 3 || k == 7) ? 1 : 0);
      s1 = {$urandom, 1'b0} | (((k >= 3 && k < 6) || k == 7) ? 1 : 0);
      md = $urandom;
      sz = ($urandom % 10 < 8) ? ($urandom % 4) : ($urandom | 32'h4);
      ad = $urandom; wd = $urandom;
      lat_cfg = $urandom % 4;
      resp_err = ($urandom % 6 == 0);
      resp_rdata = $urandom;
      wr(12'h010, s0); wr(12'h028, s1);
      wr(12'(12'h014 + c * 'h18), md);
      wr(12'(12'h018 + c * 'h18), sz);
      wr(12'(12'h01C + c * 'h18), ad);
      wr(12'(12'h020 + c * 'h18), wd);
      if (it % 16 == 0) begin
        rd(12'(12'h01C + c * 'h18), r); chk("R2 address readback", r, ad);
      end
      go = legal(s0, s1, sz);
      n0 = n_txn;
      wr(12'h004, $urandom);
      repeat (8) @(posedge clk);
      chk(sz[31:2] != 0 || sz[1:0] == 2 ? "R6 rejection" : "R3 issue count",
          n_txn - n0, go ? 1 : 0);
      if (go) begin
        chk("R3 channel", got_chan, c);
        chk("R3 address", got_addr, ad);
        chk("R4 direction", got_we, !md[0]);
        chk("R5 width code", got_size, sz[1:0]);
        chk("R11 write data lanes", got_wdata, wd & keep(sz[1:0]));
        if (!resp_err) begin
          exp_done[c] = 1;
          if (md[0]) exp_rd[c] = resp_rdata & keep(sz[1:0]);
        end
      end
      rd(12'h048, r); chk(resp_err ? "R9 status" : "R7 status", r, {14'b0, exp_done, 16'b0});
      rd(12'h084, r); chk(resp_err ? "R9 result0" : "R8 result0", r, exp_rd[0]);
      rd(12'h090, r); chk(resp_err ? "R9 result1" : "R8 result1", r, exp_rd[1]);
      if ($urandom % 3 == 0) begin
        logic [31:0] m;
        m = $urandom;
        wr(12'h048, m);
        exp_done = exp_done & ~m[17:16];
        rd(12'h048, r); chk("R7 clear by writing one", r, {14'b0, exp_done, 16'b0});
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule